// File: doc/BRIEF.md
# Oversampling touch-ADC scan sequencer

This block is a scan sequencer for a serial touch and auxiliary ADC. It drives the converter as an SPI master in mode 0. On a start pulse it walks an 8-bit channel mask from the lowest index to the highest. For every enabled channel it issues a group of 24-bit sample frames. Each frame is one command byte out followed by a 16-bit word in. The block throws away the first settling samples of the group and averages the rest, rounding up. The 12-bit average goes into the next free slot of a result register file.

Each channel has its own skip count and oversampling ratio. The command byte depends on the channel: the single-ended reference and the reference-on bit are set only for the temperature, battery and auxiliary inputs. Every sample of a group holds the converter powered except the last one, which requests automatic power-down. Chip select stays low for the whole scan. A one-cycle done pulse marks the end of the scan, and by then every result slot has been written.

Top module: `touch_scan_seq`

## Requirements
- R1: Each command byte has bit 7 = 1, bits 6:4 = the channel index (0 temp0, 1 Y, 2 battery, 3 Z1, 4 Z2, 5 X, 6 auxiliary, 7 temp1) and bit 3 = 0 (12-bit conversion).
- R2: For channels 0, 2, 6 and 7, bit 2 (single-ended) is 1, and bit 1 (reference on) is 1 on every sample except the last of the group. For channels 1, 3, 4 and 5, bits 2 and 1 are always 0.
- R3: Bit 0 (converter on) is 1 on every sample of a group except the last. The last sample has bits 1:0 = 00.
- R4: A frame is 24 SCLK cycles in mode 0: SCLK idles low, MOSI changes only while SCLK is low, and the command is sent MSB first. The sample value is bits 14:3 of the 16 bits received MSB first after the command byte.
- R5: A channel's group holds skip + ratio frames. The first skip samples are excluded from the average.
- R6: The channel result is the sum of the kept samples divided by their count, rounded up.
- R7: Enabled channels are handled in ascending index order. Their results fill slots 0, 1, 2, … consecutively, and `result_cnt_o` gives the number filled. Slots not filled by the current scan read 0.
- R8: An oversampling ratio of 0 is treated as 1. Ratios of 1 to 255 are used as given.
- R9: `spi_cs_no` is low throughout a scan and high when idle. SCLK never pulses while chip select is high.
- R10: A start pulse while the block is busy is ignored. It neither changes the running scan nor queues a second one.
- R11: `done_o` is a single-cycle pulse that follows the write of the last result. An empty mask produces done with no frames and a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan (ignored while busy) |
| chan_mask_i | input | NUM_CH | Channels to scan, sampled at start |
| skip_cfg_i | input | NUM_CH*SKIP_W | Per-channel settling sample count |
| ratio_cfg_i | input | NUM_CH*RATIO_W | Per-channel oversampling ratio |
| spi_sclk_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | Command data to the converter |
| spi_miso_i | input | 1 | Sample data from the converter |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| result_cnt_o | output | $clog2(NUM_CH)+1 | Number of result slots filled |
| result_o | output | NUM_CH*12 | Result slots, slot i in bits 12*i+11:12*i |

## Verification
A frame takes 48*HALF_DIV clocks plus a cycle of launch overhead. Each channel's divide adds about 22 clocks, and done rises one clock after the final slot write. The bench checks every command byte on the SCLK rise that completes its eighth bit, against a queue filled in advance by the driver. It checks the result slots on the falling clock edge where done is high, and the next falling edge must show done low again. Each scan must reach done within a window computed from its frame count. After done the bench checks the total SCLK count and the absence of any extra scan.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
  localparam int FRAME_BITS = 24;
  localparam int RES_W      = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_LAUNCH, ST_XFER, ST_DIV_GO, ST_DIV_WAIT
  } seq_state_e;

  function automatic logic ch_single_ended(input logic [2:0] ch);
    return (ch == 3'd0) || (ch == 3'd2) || (ch == 3'd6) || (ch == 3'd7);
  endfunction

  // start | addr | 12-bit | ser | vref_on | adc_on
  function automatic logic [7:0] make_cmd(input logic [2:0] ch, input logic last);
    logic se;
    se = ch_single_ended(ch);
    return {1'b1, ch, 1'b0, se, se & ~last, ~last};
  endfunction
endpackage

// File: rtl/tscan_spi_frame.sv
module tscan_spi_frame
  import tscan_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [7:0]       cmd_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [RES_W-1:0] sample_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] bit_q;
  logic [FRAME_BITS-1:0] tx_q;
  logic [14:0] rx_q;
  logic sclk_q, busy_q, done_q;
  logic tick;

  assign tick = busy_q && (div_q == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          tx_q   <= {cmd_i, 16'h0000};
          div_q  <= '0;
          bit_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (!tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[13:0], miso_i};
          bit_q  <= bit_q + 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == CNT_W'(FRAME_BITS)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign mosi_o   = busy_q & tx_q[FRAME_BITS-1];
  assign done_o   = done_q;
  assign sample_o = rx_q[14:3];

  // R4
  mosi_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));
  // R4
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (bit_q == CNT_W'(FRAME_BITS)));
endmodule

// File: rtl/tscan_ceil_div.sv
module tscan_ceil_div #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 8,
  parameter int OUT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W-1:0]  rem_q, den_q;
  logic [STEP_W-1:0] step_q;
  logic busy_q, done_q;
  logic [DEN_W:0] shifted, diff;
  logic ge;
  logic [NUM_W-1:0] ceil_w;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    ge      = shifted >= {1'b0, den_q};
    diff    = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          quo_q  <= num_i;
          rem_q  <= '0;
          den_q  <= den_i;
          step_q <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        rem_q  <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], ge};
        step_q <= step_q + 1'b1;
        if (step_q == STEP_W'(NUM_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // nonzero remainder bumps the quotient up
  assign ceil_w = quo_q + NUM_W'(rem_q != '0);
  assign quo_o  = ceil_w[OUT_W-1:0];
  assign done_o = done_q;

  // R8
  den_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (den_i != '0));
  // R6
  avg_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (ceil_w[NUM_W-1:OUT_W] == '0));
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
  import tscan_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SKIP_W   = 4,
  parameter int RATIO_W  = 8,
  parameter int HALF_DIV = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [NUM_CH-1:0]         chan_mask_i,
  input  logic [NUM_CH*SKIP_W-1:0]  skip_cfg_i,
  input  logic [NUM_CH*RATIO_W-1:0] ratio_cfg_i,
  output logic                      spi_sclk_o,
  output logic                      spi_cs_no,
  output logic                      spi_mosi_o,
  input  logic                      spi_miso_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [$clog2(NUM_CH):0]   result_cnt_o,
  output logic [NUM_CH*RES_W-1:0]   result_o
);
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int CH_W   = IDX_W + 1;
  localparam int SAMP_W = ((SKIP_W > RATIO_W) ? SKIP_W : RATIO_W) + 1;
  localparam int SUM_W  = RATIO_W + RES_W;

  seq_state_e state_q;
  logic [NUM_CH-1:0]  mask_q;
  logic [CH_W-1:0]    ch_q, slot_q;
  logic [SAMP_W-1:0]  samp_q, total;
  logic [SKIP_W-1:0]  skip_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [SUM_W-1:0]   acc_q;
  logic               cs_n_q, done_q;
  logic [RES_W-1:0]   res_q [NUM_CH];

  logic [SKIP_W-1:0]  skip_arr  [NUM_CH];
  logic [RATIO_W-1:0] ratio_arr [NUM_CH];

  logic [IDX_W-1:0] ch_idx, slot_idx;
  logic             last, keep;
  logic [7:0]       cmd;
  logic             xfer_go, xfer_done;
  logic [RES_W-1:0] xfer_sample;
  logic             div_go, div_done;
  logic [RES_W-1:0] div_quo;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_cfg
      assign skip_arr[g]  = skip_cfg_i[g*SKIP_W +: SKIP_W];
      // zero ratio behaves as one
      assign ratio_arr[g] = (ratio_cfg_i[g*RATIO_W +: RATIO_W] == '0) ?
                            RATIO_W'(1) : ratio_cfg_i[g*RATIO_W +: RATIO_W];
      assign result_o[g*RES_W +: RES_W] = res_q[g];
    end
  endgenerate

  assign ch_idx   = ch_q[IDX_W-1:0];
  assign slot_idx = slot_q[IDX_W-1:0];
  assign total    = SAMP_W'(skip_q) + SAMP_W'(ratio_q);
  assign last     = (samp_q == total - 1'b1);
  assign keep     = (samp_q >= SAMP_W'(skip_q));
  assign cmd      = make_cmd(3'(ch_idx), last);
  assign xfer_go  = (state_q == ST_LAUNCH);
  assign div_go   = (state_q == ST_DIV_GO);

  tscan_spi_frame #(.HALF_DIV(HALF_DIV)) frame_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (xfer_go),
    .cmd_i    (cmd),
    .miso_i   (spi_miso_i),
    .sclk_o   (spi_sclk_o),
    .mosi_o   (spi_mosi_o),
    .done_o   (xfer_done),
    .sample_o (xfer_sample)
  );

  tscan_ceil_div #(.NUM_W(SUM_W), .DEN_W(RATIO_W), .OUT_W(RES_W)) div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_go),
    .num_i   (acc_q),
    .den_i   (ratio_q),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      ch_q    <= '0;
      slot_q  <= '0;
      samp_q  <= '0;
      skip_q  <= '0;
      ratio_q <= RATIO_W'(1);
      acc_q   <= '0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) res_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mask_q  <= chan_mask_i;
          ch_q    <= '0;
          slot_q  <= '0;
          cs_n_q  <= 1'b0;
          for (int i = 0; i < NUM_CH; i++) res_q[i] <= '0;
          state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (ch_q == CH_W'(NUM_CH)) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (mask_q[ch_idx]) begin
            skip_q  <= skip_arr[ch_idx];
            ratio_q <= ratio_arr[ch_idx];
            samp_q  <= '0;
            acc_q   <= '0;
            state_q <= ST_LAUNCH;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end
        ST_LAUNCH: state_q <= ST_XFER;
        ST_XFER: if (xfer_done) begin
          if (keep) acc_q <= acc_q + SUM_W'(xfer_sample);
          if (last) begin
            state_q <= ST_DIV_GO;
          end else begin
            samp_q  <= samp_q + 1'b1;
            state_q <= ST_LAUNCH;
          end
        end
        ST_DIV_GO: state_q <= ST_DIV_WAIT;
        ST_DIV_WAIT: if (div_done) begin
          res_q[slot_idx] <= div_quo;
          slot_q  <= slot_q + 1'b1;
          ch_q    <= ch_q + 1'b1;
          state_q <= ST_NEXT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_no    = cs_n_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign result_cnt_o = slot_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R7
  slot_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (int'(slot_q) == $countones(mask_q)));
  // R9
  cs_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> !spi_cs_no);
  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mask_q));
endmodule

// File: tb/touch_scan_seq_tb.sv
module touch_scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH   = 8;
  localparam int SKIP_W   = 4;
  localparam int RATIO_W  = 8;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NUM_CH-1:0] mask = '0;
  logic [NUM_CH*SKIP_W-1:0]  skip_cfg = '0;
  logic [NUM_CH*RATIO_W-1:0] ratio_cfg = '0;
  logic miso = 1'b1;
  wire sclk, cs_n, mosi, busy, done;
  wire [3:0] res_cnt;
  wire [NUM_CH*12-1:0] result;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int exp_cmd_q[$];
  int exp_res_q[$];
  int sl_fidx = 0;
  int sl_rise = 0;
  int sl_cs_bad = 0;
  logic [7:0]  sl_cmd = '0;
  logic [15:0] sl_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  touch_scan_seq #(.NUM_CH(NUM_CH), .SKIP_W(SKIP_W), .RATIO_W(RATIO_W),
                   .HALF_DIV(HALF_DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_mask_i(mask),
    .skip_cfg_i(skip_cfg), .ratio_cfg_i(ratio_cfg),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .busy_o(busy), .done_o(done), .result_cnt_o(res_cnt), .result_o(result)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sample_val(input int ch, input int f);
    return (ch * 611 + f * 173 + 29) % 4096;
  endfunction

  // converter model: checks commands, answers {1, value, 3'b101}
  always @(posedge sclk) begin
    int k;
    int e;
    k = sl_rise % 24;
    if (cs_n) sl_cs_bad++;
    sl_cmd = {sl_cmd[6:0], mosi};
    sl_rise++;
    if (k == 7) begin
      sl_word = {1'b1, 12'(sample_val(int'(sl_cmd[6:4]), sl_fidx)), 3'b101};
      sl_fidx++;
      if (exp_cmd_q.size() == 0) check("R1 unexpected frame", 1, 0);
      else begin
        e = exp_cmd_q.pop_front();
        check("R1/R2/R3 command byte", int'(sl_cmd), e);
      end
    end
  end

  always @(negedge sclk or negedge cs_n) begin
    int k;
    k = sl_rise % 24;
    miso <= (k < 8) ? 1'b1 : sl_word[23-k];
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        check("R7 result count", int'(res_cnt), exp_res_q.pop_front());
        for (int i = 0; i < NUM_CH; i++)
          check("R6/R7 slot value", int'(result[i*12 +: 12]), exp_res_q.pop_front());
        done_cnt++;
        @(negedge clk);
        check("R11 done single cycle", int'(done), 0);
      end
    end
  end

  task automatic run_scan(input logic [7:0] m, input int sk[NUM_CH],
                          input int ra[NUM_CH], input bit poke);
    int f = 0;
    int frames = 0;
    int cnt = 0;
    int res[NUM_CH];
    int prev;
    int t = 0;
    int limit;
    for (int c = 0; c < NUM_CH; c++) res[c] = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (m[c]) begin
        int r;
        int n;
        int sum;
        bit se;
        r = (ra[c] == 0) ? 1 : ra[c];
        n = sk[c] + r;
        sum = 0;
        se = (c == 0) || (c == 2) || (c == 6) || (c == 7);
        for (int s = 0; s < n; s++) begin
          bit last;
          int v;
          last = (s == n - 1);
          exp_cmd_q.push_back(128 + c * 16 + (se ? 4 : 0) + ((se && !last) ? 2 : 0) + (last ? 0 : 1));
          v = sample_val(c, f);
          f++;
          if (s >= sk[c]) sum += v;
        end
        res[cnt] = (sum + r - 1) / r;
        cnt++;
        frames += n;
      end
      skip_cfg[c*SKIP_W +: SKIP_W]    = SKIP_W'(sk[c]);
      ratio_cfg[c*RATIO_W +: RATIO_W] = RATIO_W'(ra[c]);
    end
    exp_res_q.push_back(cnt);
    for (int i = 0; i < NUM_CH; i++) exp_res_q.push_back(res[i]);
    sl_fidx = 0;
    sl_rise = 0;
    sl_cs_bad = 0;
    prev = done_cnt;
    limit = frames * (48 * HALF_DIV + 8) + NUM_CH * 30 + 50;
    mask = m;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (200) @(negedge clk);
      mask = 8'hFF;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (done_cnt == prev && t < limit) begin
      @(negedge clk);
      t++;
    end
    check("R11 done within window", int'(done_cnt != prev), 1);
    repeat (4) @(negedge clk);
    check("R4 SCLK rises per scan", sl_rise, frames * 24);
    check("R9 no SCLK with CS high", sl_cs_bad, 0);
    check("R5 all frames issued", exp_cmd_q.size(), 0);
    check("R10 idle after scan", int'(busy), 0);
    check("R9 CS high after scan", int'(cs_n), 1);
    exp_cmd_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int sk[NUM_CH];
    int ra[NUM_CH];
    repeat (3) @(negedge clk);
    check("R9 reset CS high", int'(cs_n), 1);
    check("R4 reset SCLK low", int'(sclk), 0);
    check("R11 reset done low", int'(done), 0);
    check("R7 reset count zero", int'(res_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // all channels, skip 1, ratio 1
    for (int c = 0; c < NUM_CH; c++) begin sk[c] = 1; ra[c] = 1; end
    run_scan(8'hFF, sk, ra, 1'b0);

    // mixed groups; channel 2 ratio 0 acts as 1 (R8)
    for (int c = 0; c < NUM_CH; c++) begin sk[c] = 0; ra[c] = 1; end
    sk[0] = 2; ra[0] = 3;
    sk[2] = 0; ra[2] = 0;
    sk[5] = 3; ra[5] = 4;
    sk[7] = 1; ra[7] = 2;
    run_scan(8'hA5, sk, ra, 1'b0);

    // empty mask (R11)
    run_scan(8'h00, sk, ra, 1'b0);

    // largest ratio, no skip (R6)
    for (int c = 0; c < NUM_CH; c++) begin sk[c] = 0; ra[c] = 1; end
    ra[4] = 255;
    run_scan(8'h10, sk, ra, 1'b0);

    // full scan then a short one with a start poked mid-scan (R10, R7 cleared slots)
    for (int c = 0; c < NUM_CH; c++) begin sk[c] = 1; ra[c] = 2; end
    run_scan(8'hFF, sk, ra, 1'b0);
    sk[1] = 2; ra[1] = 5; sk[5] = 0; ra[5] = 3;
    run_scan(8'h22, sk, ra, 1'b1);

    repeat (50) @(negedge clk);
    check("R10 no queued scan", int'(busy), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule